// File: doc/BRIEF.md
# L1 Link Power Management Sleep Controller

This block follows the L1 (LPM sleep) state of a full-speed USB port, and it works in both device and host roles. The packet engine reports the result of every LPM transaction as a one-cycle pulse carrying a two-bit handshake code. The block keeps the most recent code and decides whether the port enters sleep. A device waits out a residency interval after an ACK before it sleeps. A host sleeps on the cycle after the ACK. Software and line events reach the block as single-cycle strobes, and any strobe that applies to the current role wakes the port.

While the port is asleep, a dwell counter runs for 50 µs, computed from the clock frequency parameter. When it finishes, the block raises a flag meaning resume may begin. The PHY-suspend request is asserted only while the port is asleep and software has set both the deep-sleep enable and the stop-clock control.

The controller has four states:
- `ST_AWAKE`: the port is active.
- `ST_RESIDE`: device role only. An ACK has been sent and the residency count is running.
- `ST_SLEEP`: the port is in L1 and the dwell count is running.
- `ST_READY`: the port is in L1 and resume is permitted.

The transitions are:
- AWAKE→RESIDE on an ACK in device role.
- AWAKE→SLEEP on an ACK in host role.
- RESIDE→SLEEP when the residency count expires.
- SLEEP→READY when the dwell count expires.
- RESIDE, SLEEP or READY→AWAKE on any exit strobe that applies to the role.

Top module: `lpm_sleep_ctrl`

## Requirements
- R1: After a synchronous reset, the block is in ST_AWAKE. `sleep_sts`, `resume_ok` and `phy_susp` are 0, and `hs_code` is 00.
- R2: Each cycle with `hs_valid` high stores `hs_code_in` into `hs_code`, visible from the next cycle. The codes are 11 ACK, 10 NYET, 01 STALL and 00 ERROR (no handshake). Without `hs_valid`, `hs_code` holds its value.
- R3: In host role (`host_role`=1), an ACK received while awake sets `sleep_sts` on the next cycle. Any other code leaves the port awake.
- R4: In device role, an ACK received while awake enters ST_RESIDE. `sleep_sts` rises exactly RESID_CYCLES cycles after the ACK cycle. Any other code leaves the port awake.
- R5: `resume_ok` rises exactly DWELL cycles after `sleep_sts` rises, where DWELL = ceil(CLK_KHZ·50/1000), which is 2400 at 48 MHz. `resume_ok` is 0 whenever `sleep_sts` is 0.
- R6: In device role, each of `line_act`, `sw_rwake`, `bus_reset` and `soft_disc` returns the block from ST_RESIDE, ST_SLEEP or ST_READY to ST_AWAKE. In host role these four strobes have no effect.
- R7: In host role, each of `rmt_wake`, `port_rst`, `port_res`, `wake_irq` and `disc_irq` returns the block from any sleep state to ST_AWAKE. In device role these five strobes have no effect.
- R8: When an applicable exit strobe and an ACK arrive in the same cycle, the block ends in ST_AWAKE, and the ACK code is still recorded.
- R9: `phy_susp` is 1 exactly when `sleep_sts`, `deep_en` and `stop_clk` are all 1.
- R10: A handshake received while in ST_SLEEP or ST_READY is recorded but does not change the state. In particular, `resume_ok` stays high in ST_READY.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| host_role | input | 1 | 1 = host role, 0 = device role |
| hs_valid | input | 1 | LPM transaction result pulse |
| hs_code_in | input | 2 | Handshake code of that result |
| line_act | input | 1 | Device exit: line-state activity |
| sw_rwake | input | 1 | Device exit: software remote-wakeup signalling |
| bus_reset | input | 1 | Device exit: bus reset |
| soft_disc | input | 1 | Device exit: soft disconnect |
| rmt_wake | input | 1 | Host exit: remote L1 wakeup detected |
| port_rst | input | 1 | Host exit: software port reset |
| port_res | input | 1 | Host exit: software port resume |
| wake_irq | input | 1 | Host exit: wakeup-detected interrupt raised |
| disc_irq | input | 1 | Host exit: disconnect interrupt raised |
| deep_en | input | 1 | Deep-sleep enable |
| stop_clk | input | 1 | Software stop-clock control |
| sleep_sts | output | 1 | Port is in L1 |
| resume_ok | output | 1 | Resume from L1 permitted |
| hs_code | output | 2 | Last recorded handshake code |
| phy_susp | output | 1 | PHY suspend request |

## Verification
The hardest situations to reach are an exit strobe that lands partway through the device residency count, and a strobe from the wrong role. The wrong-role strobe must leave both counters running on schedule.

The bench reaches these cases with a sweep over both roles, all nine exit strobes and the three non-awake states. For each case it walks the block into the target state with cycle-exact checks on the way. It then applies the strobe and computes from RESID_CYCLES and DWELL the cycle on which `sleep_sts` and `resume_ok` must next change.

Same-cycle collisions of an ACK with an exit are produced by driving both inputs in one cycle, once while awake and once while asleep.

// File: rtl/lpm_pkg.sv
package lpm_pkg;

    typedef enum logic [1:0] {
        ST_AWAKE  = 2'd0,
        ST_RESIDE = 2'd1,
        ST_SLEEP  = 2'd2,
        ST_READY  = 2'd3
    } lpm_state_e;

    typedef enum logic [1:0] {
        HS_ERROR = 2'b00,
        HS_STALL = 2'b01,
        HS_NYET  = 2'b10,
        HS_ACK   = 2'b11
    } lpm_hs_e;

    localparam int DEV_EXITS  = 4;
    localparam int HOST_EXITS = 5;

endpackage

// File: rtl/lpm_exit_sel.sv
module lpm_exit_sel #(
    parameter int N_DEV  = 4,
    parameter int N_HOST = 5
) (
    input  logic              host_role,
    input  logic [N_DEV-1:0]  dev_ev,
    input  logic [N_HOST-1:0] host_ev,
    output logic              exit_req
);
    logic [N_DEV:0]  dev_or;
    logic [N_HOST:0] host_or;

    assign dev_or[0]  = 1'b0;
    assign host_or[0] = 1'b0;

    // chain OR over each role's strobe set
    for (genvar i = 0; i < N_DEV; i++) begin : g_dev
        assign dev_or[i+1] = dev_or[i] | dev_ev[i];
    end
    for (genvar j = 0; j < N_HOST; j++) begin : g_host
        assign host_or[j+1] = host_or[j] | host_ev[j];
    end

    assign exit_req = host_role ? host_or[N_HOST] : dev_or[N_DEV];
endmodule

// File: rtl/lpm_tick_cnt.sv
module lpm_tick_cnt #(
    parameter int LIMIT = 16
) (
    input  logic clk,
    input  logic rst,
    input  logic run,
    output logic done
);
    localparam int W = (LIMIT > 1) ? $clog2(LIMIT) : 1;
    localparam logic [W-1:0] LAST = W'(LIMIT - 1);

    logic [W-1:0] cnt;

    assign done = run && (cnt == LAST);

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt <= '0;
        end else if (!done) begin
            cnt <= cnt + W'(1);
        end
    end

    // R5 / R4: the count never passes its terminal value
    p_cnt_bound_r5: assert property (@(posedge clk) disable iff (rst)
        cnt <= LAST);

    p_cnt_restart_r4: assert property (@(posedge clk) disable iff (rst)
        !run |=> cnt == '0);
endmodule

// File: rtl/lpm_hs_rec.sv
module lpm_hs_rec (
    input  logic       clk,
    input  logic       rst,
    input  logic       hs_valid,
    input  logic [1:0] hs_code_in,
    output logic [1:0] hs_code
);
    import lpm_pkg::*;

    always_ff @(posedge clk) begin
        if (rst) begin
            hs_code <= HS_ERROR;
        end else if (hs_valid) begin
            hs_code <= hs_code_in;
        end
    end

    p_hs_capture_r2: assert property (@(posedge clk) disable iff (rst)
        hs_valid |=> hs_code == $past(hs_code_in));

    p_hs_hold_r2: assert property (@(posedge clk) disable iff (rst)
        !hs_valid |=> $stable(hs_code));
endmodule

// File: rtl/lpm_sleep_ctrl.sv
module lpm_sleep_ctrl #(
    parameter int CLK_KHZ      = 48000,
    parameter int RESID_CYCLES = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       host_role,
    input  logic       hs_valid,
    input  logic [1:0] hs_code_in,
    input  logic       line_act,
    input  logic       sw_rwake,
    input  logic       bus_reset,
    input  logic       soft_disc,
    input  logic       rmt_wake,
    input  logic       port_rst,
    input  logic       port_res,
    input  logic       wake_irq,
    input  logic       disc_irq,
    input  logic       deep_en,
    input  logic       stop_clk,
    output logic       sleep_sts,
    output logic       resume_ok,
    output logic [1:0] hs_code,
    output logic       phy_susp
);
    import lpm_pkg::*;

    // 50 us dwell expressed in clock cycles, rounded up, at least one
    localparam int DWELL_RAW = (CLK_KHZ * 50 + 999) / 1000;
    localparam int DWELL     = (DWELL_RAW < 1) ? 1 : DWELL_RAW;
    localparam int RESID     = (RESID_CYCLES < 1) ? 1 : RESID_CYCLES;

    lpm_state_e state, nxt;
    logic       exit_req;
    logic       ack_in;
    logic       resid_done;
    logic       dwell_done;

    lpm_exit_sel #(
        .N_DEV  (DEV_EXITS),
        .N_HOST (HOST_EXITS)
    ) u_exit (
        .host_role (host_role),
        .dev_ev    ({soft_disc, bus_reset, sw_rwake, line_act}),
        .host_ev   ({disc_irq, wake_irq, port_res, port_rst, rmt_wake}),
        .exit_req  (exit_req)
    );

    lpm_tick_cnt #(.LIMIT(RESID)) u_resid (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_RESIDE),
        .done (resid_done)
    );

    lpm_tick_cnt #(.LIMIT(DWELL)) u_dwell (
        .clk  (clk),
        .rst  (rst),
        .run  (state == ST_SLEEP),
        .done (dwell_done)
    );

    lpm_hs_rec u_hs (
        .clk        (clk),
        .rst        (rst),
        .hs_valid   (hs_valid),
        .hs_code_in (hs_code_in),
        .hs_code    (hs_code)
    );

    assign ack_in = hs_valid && (hs_code_in == HS_ACK);

    // state register
    always_ff @(posedge clk) begin
        if (rst) begin
            state <= ST_AWAKE;
        end else begin
            state <= nxt;
        end
    end

    // next state: exit strobes outrank entry and timer expiry
    always_comb begin
        nxt = state;
        unique case (state)
            ST_AWAKE: begin
                if (!exit_req && ack_in) begin
                    nxt = host_role ? ST_SLEEP : ST_RESIDE;
                end
            end
            ST_RESIDE: begin
                if (exit_req)        nxt = ST_AWAKE;
                else if (resid_done) nxt = ST_SLEEP;
            end
            ST_SLEEP: begin
                if (exit_req)        nxt = ST_AWAKE;
                else if (dwell_done) nxt = ST_READY;
            end
            ST_READY: begin
                if (exit_req)        nxt = ST_AWAKE;
            end
            default: nxt = ST_AWAKE;
        endcase
    end

    // outputs
    always_comb begin
        sleep_sts = (state == ST_SLEEP) || (state == ST_READY);
        resume_ok = (state == ST_READY);
        phy_susp  = sleep_sts && deep_en && stop_clk;
    end

    p_exit_wins_r8: assert property (@(posedge clk) disable iff (rst)
        exit_req |=> (state == ST_AWAKE));

    p_host_entry_r3: assert property (@(posedge clk) disable iff (rst)
        (host_role && ack_in && !exit_req && state == ST_AWAKE) |=> sleep_sts);

    p_dev_via_reside_r4: assert property (@(posedge clk) disable iff (rst)
        (!host_role && $rose(sleep_sts)) |-> $past(state) == ST_RESIDE);

    p_ready_after_sleep_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(resume_ok) |-> $past(sleep_sts));

    p_phy_awake_off_r9: assert property (@(posedge clk) disable iff (rst)
        !sleep_sts |-> !phy_susp);

    p_sleep_hs_keeps_r10: assert property (@(posedge clk) disable iff (rst)
        (state == ST_READY && !exit_req) |=> resume_ok);
endmodule

// File: tb/sim_lpm_sleep_ctrl.sv
module sim_lpm_sleep_ctrl;
    localparam int CLK_KHZ = 100;   // dwell = 5 cycles
    localparam int RESID   = 3;
    localparam int DWELL   = (CLK_KHZ * 50 + 999) / 1000;

    logic       clk = 1'b0;
    logic       rst;
    logic       host_role;
    logic       hs_valid;
    logic [1:0] hs_code_in;
    logic [8:0] ev;
    logic       deep_en, stop_clk;
    logic       sleep_sts, resume_ok, phy_susp;
    logic [1:0] hs_code;

    int checks   = 0;
    int failures = 0;

    always #10 clk = ~clk;   // 50 MHz

    lpm_sleep_ctrl #(.CLK_KHZ(CLK_KHZ), .RESID_CYCLES(RESID)) u0 (
        .clk(clk), .rst(rst), .host_role(host_role),
        .hs_valid(hs_valid), .hs_code_in(hs_code_in),
        .line_act(ev[0]), .sw_rwake(ev[1]), .bus_reset(ev[2]), .soft_disc(ev[3]),
        .rmt_wake(ev[4]), .port_rst(ev[5]), .port_res(ev[6]),
        .wake_irq(ev[7]), .disc_irq(ev[8]),
        .deep_en(deep_en), .stop_clk(stop_clk),
        .sleep_sts(sleep_sts), .resume_ok(resume_ok),
        .hs_code(hs_code), .phy_susp(phy_susp)
    );

    task automatic chk(input int got, input int exp, input string tag);
        checks++;
        if (got != exp) begin
            failures++;
            $display("FAIL %s got=%0d exp=%0d", tag, got, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    task automatic do_reset;
        rst = 1'b1; hs_valid = 1'b0; hs_code_in = 2'b00; ev = '0;
        deep_en = 1'b0; stop_clk = 1'b0;
        tick(); tick();
        rst = 1'b0;
        chk(sleep_sts, 0, "R1 sleep_sts");
        chk(resume_ok, 0, "R1 resume_ok");
        chk(hs_code, 0, "R1 hs_code");
        chk(phy_susp, 0, "R1 phy_susp");
    endtask

    task automatic send_hs(input logic [1:0] code);
        hs_valid = 1'b1; hs_code_in = code;
        tick();
        hs_valid = 1'b0;
    endtask

    // phase 0 = residency (device only), 1 = sleep dwell, 2 = resume ready
    task automatic go_phase(input int phase);
        send_hs(2'b11);
        if (!host_role) begin
            chk(sleep_sts, 0, "R4 reside no sleep yet");
            if (phase == 0) return;
            for (int k = 1; k <= RESID; k++) begin
                tick();
                chk(sleep_sts, (k == RESID) ? 1 : 0, "R4 residency timing");
            end
        end else begin
            chk(sleep_sts, 1, "R3 host entry");
        end
        chk(resume_ok, 0, "R5 not yet ready");
        if (phase == 1) return;
        for (int k = 1; k <= DWELL; k++) begin
            tick();
            chk(resume_ok, (k == DWELL) ? 1 : 0, "R5 dwell timing");
        end
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        failures++;
        $display("FAIL watchdog expired");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        host_role = 1'b0;
        do_reset();

        // R2 / R3 / R4: every handshake code in both roles
        for (int r = 0; r < 2; r++) begin
            for (int c = 0; c < 4; c++) begin
                host_role = r[0];
                do_reset();
                send_hs(c[1:0]);
                chk(hs_code, c, "R2 code recorded");
                if (r == 1) begin
                    chk(sleep_sts, (c == 3) ? 1 : 0, "R3 host entry by code");
                end else begin
                    repeat (RESID) tick();
                    chk(sleep_sts, (c == 3) ? 1 : 0, "R4 device entry by code");
                end
                chk(hs_code, c, "R2 code held");
            end
        end

        // R6 / R7: every exit strobe, both roles, every non-awake state
        for (int r = 0; r < 2; r++) begin
            for (int e = 0; e < 9; e++) begin
                for (int ph = 0; ph < 3; ph++) begin
                    bit applies;
                    if (r == 1 && ph == 0) continue;
                    host_role = r[0];
                    applies = (r == 1) ? (e >= 4) : (e < 4);
                    do_reset();
                    go_phase(ph);
                    ev[e] = 1'b1;
                    tick();
                    ev = '0;
                    if (applies) begin
                        chk(sleep_sts, 0, (r == 1) ? "R7 host exit" : "R6 device exit");
                        chk(resume_ok, 0, "R5 resume_ok cleared");
                        repeat (RESID + DWELL + 2) tick();
                        chk(sleep_sts, 0, (r == 1) ? "R7 stays awake" : "R6 stays awake");
                    end else begin
                        chk(sleep_sts, (ph == 0 && RESID > 1) ? 0 : 1,
                            (r == 1) ? "R6 device strobe ignored in host" :
                                       "R7 host strobe ignored in device");
                        if (ph == 0) repeat (RESID - 1 + DWELL) tick();
                        else if (ph == 1) repeat (DWELL - 1) tick();
                        chk(resume_ok, 1, (r == 1) ? "R6 timers unaffected" :
                                                     "R7 timers unaffected");
                    end
                end
            end
        end

        // R8: ACK and applicable exit in the same cycle
        for (int r = 0; r < 2; r++) begin
            host_role = r[0];
            do_reset();
            hs_valid = 1'b1; hs_code_in = 2'b11;
            ev[(r == 1) ? 5 : 0] = 1'b1;
            tick();
            hs_valid = 1'b0; ev = '0;
            chk(sleep_sts, 0, "R8 awake collision");
            chk(hs_code, 3, "R8 ack recorded");
            repeat (RESID + 1) tick();
            chk(sleep_sts, 0, "R8 no deferred entry");
            go_phase(2);
            hs_valid = 1'b1; hs_code_in = 2'b11;
            ev[(r == 1) ? 8 : 3] = 1'b1;
            tick();
            hs_valid = 1'b0; ev = '0;
            chk(sleep_sts, 0, "R8 asleep collision");
        end

        // R10: handshakes while asleep are recorded only
        for (int r = 0; r < 2; r++) begin
            host_role = r[0];
            do_reset();
            go_phase(2);
            send_hs(2'b10);
            chk(hs_code, 2, "R10 code recorded in sleep");
            chk(resume_ok, 1, "R10 ready kept");
            send_hs(2'b11);
            chk(resume_ok, 1, "R10 ack in ready ignored");
            chk(sleep_sts, 1, "R10 still asleep");
        end

        // R9: PHY suspend gating, awake and asleep
        host_role = 1'b0;
        do_reset();
        for (int g = 0; g < 4; g++) begin
            deep_en = g[0]; stop_clk = g[1];
            #1;
            chk(phy_susp, 0, "R9 awake no suspend");
        end
        deep_en = 1'b0; stop_clk = 1'b0;
        go_phase(1);
        for (int g = 0; g < 4; g++) begin
            deep_en = g[0]; stop_clk = g[1];
            #1;
            chk(phy_susp, (g == 3) ? 1 : 0, "R9 asleep gating");
        end

        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule